// File: doc/BRIEF.md
# Serial-Link Management Transaction Block Codec

This block carries register-access transactions for device management over a serial link. The transactions do not use a separate two-wire management bus. On the transmit side it takes one transaction, either a request or a response, and turns it into three 66-bit blocks. The first is a fixed-pattern opening control block. The second is one packed data block. The third is a fixed-pattern closing control block. Each block goes out on a valid/ready stream.

On the receive side it watches an incoming 66-bit block stream and waits for the opening pattern. It captures the fields of the following data block and presents the decoded transaction only after a correct closing block arrives. A block that breaks the open/data/close order abandons the transaction and raises a one-cycle error pulse.

Back-pressure works as follows:
- A transmit block stays on `tx_blk` until `tx_ready` is sampled high.
- A new transaction is taken only while `txn_ready` is high.
- A decoded transaction stays on the `out_*` pins until `out_ready` is sampled high.
- While a decoded transaction is waiting, `rx_ready` is low, so no further blocks are consumed.

Scrambling, gearboxing, serialization and the actual register access are outside this block.

Top module: `mgmt_blk_codec`

## Requirements
- R1: Every block holds its 2-bit sync field in bits [1:0]. A control block has sync 2'b10 and type byte 8'h1e in bits [9:2]. Its eight 7-bit characters sit at bits [10+7*i +: 7] for i = 0..7. The opening block carries the characters 00,00,00,00,69,78,66,33 (hex) at positions 0..7.
- R2: The closing block carries 00,00,00,00,70,78,66 (hex) at positions 0..6, and the transmitter sends 7'h00 at position 7. The receiver matches the closing block on positions 0..6 only, so any value at position 7 is accepted.
- R3: A data block has sync 2'b01 and the following fields:
  - control byte in bits [9:2]: bit 0 is read = 1 or write = 0, bit 7 is response = 1 or request = 0, and bits 6:1 are sent as zero;
  - device byte in bits [17:10]: a 6-bit device address in bits 5:0, with bits 7:6 zero;
  - register address in bits [33:18];
  - data in bits [49:34];
  - zero in bits [65:50].
- R4: In a transmitted request the data field is all zeros. In a transmitted response the device and register fields are all zeros. Both apply whatever values are on the inputs.
- R5: A transaction accepted on `txn_valid && txn_ready` appears on `tx_blk` one cycle later as opening, data and closing blocks, in that order. `txn_ready` stays low until the closing block has been taken.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_blk` and `tx_valid` hold their values.
- R7: While the receiver is waiting for an opening block, it consumes any other block with no error and no output.
- R8: When a closing block is accepted after opening and data blocks, `out_valid` rises in the next cycle. It then carries the read, response, device, register and data fields of that data block.
- R9: When the receiver is partway through a transaction, it abandons the transaction if it accepts any block other than the expected one. `rx_err` is then high for exactly one cycle, no transaction is output, and the receiver returns to waiting for an opening block.
- R10: While `out_valid` is high and `out_ready` is low, the output fields hold their values and `rx_ready` is low.
- R11: After reset, `tx_valid`, `out_valid` and `rx_err` are low, and `txn_ready` and `rx_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Transaction to send is present |
| txn_ready | output | 1 | Transmitter can take a transaction |
| txn_read | input | 1 | 1 = read, 0 = write |
| txn_resp | input | 1 | 1 = response, 0 = request |
| txn_dev | input | 6 | Device address |
| txn_reg | input | 16 | Register address |
| txn_data | input | 16 | Register data |
| tx_blk | output | 66 | Outgoing 66-bit block |
| tx_valid | output | 1 | Outgoing block is valid |
| tx_ready | input | 1 | Link takes the outgoing block |
| rx_blk | input | 66 | Incoming 66-bit block |
| rx_valid | input | 1 | Incoming block is valid |
| rx_ready | output | 1 | Receiver takes the incoming block |
| out_valid | output | 1 | Decoded transaction is present |
| out_ready | input | 1 | Consumer takes the decoded transaction |
| out_read | output | 1 | Decoded read/write bit |
| out_resp | output | 1 | Decoded response bit |
| out_dev | output | 6 | Decoded device address |
| out_reg | output | 16 | Decoded register address |
| out_data | output | 16 | Decoded data |
| rx_err | output | 1 | One-cycle pulse when a transaction is abandoned |

## Verification
The assertions check the following on every cycle:
- the transmit block and the decoded output hold while back-pressured;
- a data block is always followed by a control block;
- response blocks carry zero device and register fields;
- the error is a single-cycle pulse;
- `rx_ready` stays low while a decoded result is waiting.

The exact bit patterns of the opening and closing blocks, the field packing, the zeroing of request data, the ignored closing character and which out-of-order sequences abort can only be shown by the bench's directed scenarios. The bench compares against blocks it builds on its own.

// File: rtl/mgmt_blk_pkg.sv
package mgmt_blk_pkg;
  localparam int BLK_W    = 66;
  localparam int CHAR_W   = 7;
  localparam int N_CHARS  = 8;
  localparam int CHAR_LSB = 10;
  localparam int DEV_W    = 6;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 16;
  localparam logic [1:0] SYNC_CTRL = 2'b10;
  localparam logic [1:0] SYNC_DATA = 2'b01;
  localparam logic [7:0] CTRL_TYPE = 8'h1e;
  // closing block is only matched on positions below this
  localparam int TERM_DEF = 7;

  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    logic              rd;
    logic              resp;
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } txn_t;

  function automatic logic [CHAR_W-1:0] open_char(input int idx);
    case (idx)
      4:       return 7'h69;
      5:       return 7'h78;
      6:       return 7'h66;
      7:       return 7'h33;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [CHAR_W-1:0] close_char(input int idx);
    case (idx)
      4:       return 7'h70;
      5:       return 7'h78;
      6:       return 7'h66;
      default: return 7'h00;
    endcase
  endfunction

  function automatic blk_t build_ctrl(input logic closing);
    blk_t b;
    b = '0;
    b[1:0] = SYNC_CTRL;
    b[9:2] = CTRL_TYPE;
    for (int i = 0; i < N_CHARS; i++)
      b[CHAR_LSB + CHAR_W*i +: CHAR_W] = closing ? close_char(i) : open_char(i);
    return b;
  endfunction

  function automatic blk_t build_data(input txn_t t);
    blk_t b;
    b = '0;
    b[1:0]   = SYNC_DATA;
    b[2]     = t.rd;
    b[9]     = t.resp;
    b[15:10] = t.resp ? '0 : t.dev;
    b[33:18] = t.resp ? '0 : t.addr;
    b[49:34] = t.resp ? t.data : '0;
    return b;
  endfunction
endpackage

// File: rtl/mgmt_blk_tx.sv
module mgmt_blk_tx
  import mgmt_blk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic txn_valid,
  output logic txn_ready,
  input  txn_t txn_in,
  output blk_t tx_blk,
  output logic tx_valid,
  input  logic tx_ready
);
  typedef enum logic [1:0] {TX_IDLE, TX_OPEN, TX_DATA, TX_CLOSE} tx_st_e;
  tx_st_e st_q;
  txn_t   hold_q;

  assign txn_ready = (st_q == TX_IDLE);
  assign tx_valid  = (st_q != TX_IDLE);

  always_comb begin
    case (st_q)
      TX_OPEN:  tx_blk = build_ctrl(1'b0);
      TX_DATA:  tx_blk = build_data(hold_q);
      TX_CLOSE: tx_blk = build_ctrl(1'b1);
      default:  tx_blk = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      hold_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (txn_valid) begin
          hold_q <= txn_in;
          st_q   <= TX_OPEN;
        end
        TX_OPEN:  if (tx_ready) st_q <= TX_DATA;
        TX_DATA:  if (tx_ready) st_q <= TX_CLOSE;
        TX_CLOSE: if (tx_ready) st_q <= TX_IDLE;
        default:  st_q <= TX_IDLE;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_blk)); // R6
  AST_TX_DATA_THEN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_blk[1:0] == SYNC_DATA |=> tx_valid && tx_blk[1:0] == SYNC_CTRL); // R5
  AST_TX_RESP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_blk[1:0] == SYNC_DATA && tx_blk[9] |-> tx_blk[33:10] == '0); // R4
endmodule

// File: rtl/mgmt_blk_rx.sv
module mgmt_blk_rx
  import mgmt_blk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  blk_t rx_blk,
  input  logic rx_valid,
  output logic rx_ready,
  output logic out_valid,
  input  logic out_ready,
  output txn_t out_txn,
  output logic rx_err
);
  typedef enum logic [1:0] {RX_HUNT, RX_OPENED, RX_HAVE_DATA} rx_st_e;
  rx_st_e st_q;
  txn_t   cap_q;
  logic   out_q, err_q;

  logic [N_CHARS-1:0] open_hit, close_hit;
  logic is_ctrl, is_open, is_close, is_data, take;

  for (genvar g = 0; g < N_CHARS; g++) begin : g_match
    assign open_hit[g] = rx_blk[CHAR_LSB + CHAR_W*g +: CHAR_W] == open_char(g);
    if (g < TERM_DEF) begin : g_def
      assign close_hit[g] = rx_blk[CHAR_LSB + CHAR_W*g +: CHAR_W] == close_char(g);
    end else begin : g_free
      assign close_hit[g] = 1'b1;
    end
  end

  assign is_ctrl  = rx_blk[1:0] == SYNC_CTRL && rx_blk[9:2] == CTRL_TYPE;
  assign is_open  = is_ctrl && &open_hit;
  assign is_close = is_ctrl && &close_hit;
  assign is_data  = rx_blk[1:0] == SYNC_DATA;

  assign rx_ready  = !out_q;
  assign take      = rx_valid && rx_ready;
  assign out_valid = out_q;
  assign out_txn   = cap_q;
  assign rx_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= RX_HUNT;
      cap_q <= '0;
      out_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (out_q && out_ready) out_q <= 1'b0;
      if (take) begin
        case (st_q)
          RX_HUNT: if (is_open) st_q <= RX_OPENED;
          RX_OPENED: begin
            if (is_data) begin
              cap_q.rd   <= rx_blk[2];
              cap_q.resp <= rx_blk[9];
              cap_q.dev  <= rx_blk[15:10];
              cap_q.addr <= rx_blk[33:18];
              cap_q.data <= rx_blk[49:34];
              st_q       <= RX_HAVE_DATA;
            end else begin
              err_q <= 1'b1;
              st_q  <= RX_HUNT;
            end
          end
          RX_HAVE_DATA: begin
            if (is_close) out_q <= 1'b1;
            else          err_q <= 1'b1;
            st_q <= RX_HUNT;
          end
          default: st_q <= RX_HUNT;
        endcase
      end
    end
  end

  AST_RX_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_txn)); // R10
  AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_ready); // R10
  AST_RX_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err); // R9
  AST_RX_OUT_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rx_valid && rx_ready)); // R8
endmodule

// File: rtl/mgmt_blk_codec.sv
module mgmt_blk_codec
  import mgmt_blk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic              txn_read,
  input  logic              txn_resp,
  input  logic [DEV_W-1:0]  txn_dev,
  input  logic [ADDR_W-1:0] txn_reg,
  input  logic [DATA_W-1:0] txn_data,
  output logic [BLK_W-1:0]  tx_blk,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BLK_W-1:0]  rx_blk,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_read,
  output logic              out_resp,
  output logic [DEV_W-1:0]  out_dev,
  output logic [ADDR_W-1:0] out_reg,
  output logic [DATA_W-1:0] out_data,
  output logic              rx_err
);
  txn_t txn_in, out_txn;

  assign txn_in = '{rd: txn_read, resp: txn_resp, dev: txn_dev, addr: txn_reg, data: txn_data};

  mgmt_blk_tx u_tx (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_in(txn_in), .tx_blk(tx_blk), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  mgmt_blk_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rx_blk(rx_blk), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_txn(out_txn), .rx_err(rx_err)
  );

  assign out_read = out_txn.rd;
  assign out_resp = out_txn.resp;
  assign out_dev  = out_txn.dev;
  assign out_reg  = out_txn.addr;
  assign out_data = out_txn.data;
endmodule

// File: tb/mgmt_blk_codec_bench.sv
module mgmt_blk_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_valid = 0, txn_read = 0, txn_resp = 0;
  logic [5:0] txn_dev = 0;
  logic [15:0] txn_reg = 0, txn_data = 0;
  logic [65:0] tx_blk, rx_blk = 0;
  logic tx_valid, tx_ready = 1, rx_valid = 0, rx_ready, txn_ready;
  logic out_valid, out_ready = 1, out_read, out_resp, rx_err;
  logic [5:0] out_dev;
  logic [15:0] out_reg, out_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mgmt_blk_codec u_mgmt_blk_codec (.*);

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [65:0] mk_ctrl(input bit closing, input logic [6:0] last);
    logic [6:0] oc [8] = '{7'h00, 7'h00, 7'h00, 7'h00, 7'h69, 7'h78, 7'h66, 7'h33};
    logic [6:0] cc [8] = '{7'h00, 7'h00, 7'h00, 7'h00, 7'h70, 7'h78, 7'h66, 7'h00};
    logic [65:0] b;
    b = {56'd0, 8'h1e, 2'b10};
    for (int i = 0; i < 8; i++) b[10+7*i +: 7] = closing ? cc[i] : oc[i];
    if (closing) b[65:59] = last;
    return b;
  endfunction

  function automatic logic [65:0] mk_data(input bit rd, input bit rs, input logic [5:0] dv,
                                          input logic [15:0] rg, input logic [15:0] dt);
    return {16'd0, dt, rg, 2'b00, dv, rs, 6'd0, rd, 2'b01};
  endfunction

  task automatic rx_push(input logic [65:0] b);
    @(negedge clk);
    rx_blk = b; rx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    chk(!tx_valid && !out_valid && !rx_err && txn_ready && rx_ready, "R11 reset outputs",
        {61'd0, tx_valid, out_valid, rx_err, txn_ready, rx_ready}, 66'b00011);
  endtask

  task automatic t_tx_request;
    @(negedge clk);
    txn_valid = 1; txn_read = 1; txn_resp = 0; txn_dev = 6'h2a; txn_reg = 16'hbeef; txn_data = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    txn_valid = 0;
    chk(tx_valid && tx_blk == mk_ctrl(0, 0), "R1 opening block", tx_blk, mk_ctrl(0, 0));
    chk(!txn_ready, "R5 busy while sending", txn_ready, 0);
    @(negedge clk);
    chk(tx_valid && tx_blk == mk_data(1, 0, 6'h2a, 16'hbeef, 0), "R3 R4 request data block",
        tx_blk, mk_data(1, 0, 6'h2a, 16'hbeef, 0));
    @(negedge clk);
    chk(tx_valid && tx_blk == mk_ctrl(1, 0), "R2 closing block", tx_blk, mk_ctrl(1, 0));
    @(negedge clk);
    chk(!tx_valid && txn_ready, "R5 idle after close", {tx_valid, txn_ready}, 2'b01);
  endtask

  task automatic t_tx_response_stall;
    @(negedge clk);
    txn_valid = 1; txn_read = 0; txn_resp = 1; txn_dev = 6'h05; txn_reg = 16'habcd; txn_data = 16'h5a5a;
    tx_ready = 0;
    @(posedge clk);
    @(negedge clk);
    txn_valid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_blk == mk_ctrl(0, 0), "R6 hold under stall", tx_blk, mk_ctrl(0, 0));
    end
    tx_ready = 1;
    @(negedge clk);
    chk(tx_blk == mk_data(0, 1, 0, 0, 16'h5a5a), "R4 response data block",
        tx_blk, mk_data(0, 1, 0, 0, 16'h5a5a));
    @(negedge clk);
    chk(tx_blk == mk_ctrl(1, 0), "R5 close after data", tx_blk, mk_ctrl(1, 0));
    @(negedge clk);
  endtask

  task automatic t_rx_good;
    rx_push(mk_data(1, 0, 6'h11, 16'h2222, 0));
    chk(!out_valid && !rx_err, "R7 stray data ignored", {out_valid, rx_err}, 0);
    rx_push(mk_ctrl(1, 0));
    chk(!out_valid && !rx_err, "R7 stray close ignored", {out_valid, rx_err}, 0);
    rx_push(mk_ctrl(0, 0));
    rx_push(mk_data(1, 0, 6'h3c, 16'h8001, 0));
    out_ready = 0;
    rx_push(mk_ctrl(1, 7'h55));
    chk(out_valid && !rx_err, "R2 R8 decoded after close", {out_valid, rx_err}, 2'b10);
    chk({out_read, out_resp, out_dev, out_reg, out_data} == {1'b1, 1'b0, 6'h3c, 16'h8001, 16'h0},
        "R8 fields", {out_read, out_resp, out_dev, out_reg, out_data}, {1'b1, 1'b0, 6'h3c, 16'h8001, 16'h0});
    @(negedge clk);
    chk(out_valid && !rx_ready && out_reg == 16'h8001, "R10 hold while stalled",
        {out_valid, rx_ready, out_reg}, {2'b10, 16'h8001});
    out_ready = 1;
    @(negedge clk);
    chk(!out_valid && rx_ready, "R10 released", {out_valid, rx_ready}, 2'b01);
    rx_push(mk_ctrl(0, 0));
    rx_push(mk_data(0, 1, 0, 0, 16'hc0de));
    rx_push(mk_ctrl(1, 0));
    chk(out_valid && out_resp && !out_read && out_data == 16'hc0de, "R8 response decode",
        {out_valid, out_resp, out_read, out_data}, {3'b110, 16'hc0de});
    @(negedge clk);
  endtask

  task automatic t_rx_abort;
    rx_push(mk_ctrl(0, 0));
    rx_push(mk_ctrl(1, 0));
    chk(rx_err && !out_valid, "R9 close without data", {rx_err, out_valid}, 2'b10);
    @(negedge clk);
    chk(!rx_err, "R9 error single cycle", rx_err, 0);
    rx_push(mk_ctrl(0, 0));
    rx_push(mk_data(1, 0, 6'h01, 16'h0002, 0));
    rx_push(mk_ctrl(0, 0));
    chk(rx_err && !out_valid, "R9 open instead of close", {rx_err, out_valid}, 2'b10);
    rx_push(mk_ctrl(1, 0));
    chk(!rx_err && !out_valid, "R9 back to hunting", {rx_err, out_valid}, 0);
    rx_push(mk_ctrl(0, 0));
    rx_push(mk_data(0, 0, 6'h07, 16'h0777, 0));
    rx_push(mk_ctrl(1, 0));
    chk(out_valid && out_dev == 6'h07 && out_reg == 16'h0777, "R8 recovers after abort",
        {out_valid, out_dev, out_reg}, {1'b1, 6'h07, 16'h0777});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_request();
    t_tx_response_stall();
    t_rx_good();
    t_rx_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule